// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Read Idle Insertion

This block runs one external memory bus cycle for each accepted request. The request targets one of a small number of chip-select areas. Two bus styles are supported. In the shared address/data style, the cycle has three states: an address phase with an address latch strobe, then two strobe states. In the split address/data style, the cycle has two states: a select state, then a strobe state. A request is taken only while the sequencer is idle. A request flagged as internal, meaning it targets on-chip memory or peripheral space, skips the external bus and completes in one cycle.

Slow memories may keep driving the data bus for a while after a read. For this reason, a read cycle can be extended by one quiet idle state after its final strobe state. During the idle state no chip select, strobe or data driver is active. Each chip-select area has its own enable bit for this in a 16-bit configuration word. The enables come out of reset set. Write cycles never receive the idle state.

Top module: `extbus_seq`

## Requirements
- R1: After reset, `cfgRdData` reads 0xAAAA, which means idle insertion is enabled for every area.
- R2: In `cfgRdData`, odd bits 5 to 15 always read 1 and all even bits always read 0, whatever value is written through `cfgWrEn`/`cfgWrData`.
- R3: In shared mode (`muxMode`=1), the first cycle after the accepting edge has `busAle`, the selected chip select, and the address on `busDataOut` with `busDataOe`=1. The next two cycles hold the chip select and the read or write strobe. Without an idle state, `busDone` is high in the third cycle.
- R4: In split mode (`muxMode`=0), the selected chip select and `busAddr` are active for two cycles and the strobe is active in the second. `busAle` stays low. Without an idle state, `busDone` is high in the second cycle.
- R5: For an external read whose area has its enable bit set, one extra cycle follows the last strobe state. In that cycle all chip selects, strobes and `busDataOe` are low, and `busDone` moves into that cycle.
- R6: An external write never receives the idle cycle, whatever the enable bits say.
- R7: The enable bit for area n is configuration bit 2n+1: bit 1 for area 0 and bit 3 for area 1. A value of 1 inserts the idle cycle and 0 does not. These bits are writable.
- R8: A request with `reqInternal`=1 completes with `busDone` in the first cycle after acceptance. No chip select, strobe or bus driver becomes active.
- R9: A read samples `busDataIn` at the end of its last strobe state (T3 in shared mode, T2 in split mode). `readData` holds that value until the next read samples.
- R10: `reqReady` is high exactly while the sequencer is idle. A `reqValid` raised while busy is ignored.
- R11: A write drives `reqWdata` on `busDataOut` with `busDataOe`=1 during its strobe states, and in split mode also during T1. A read never drives the data bus except with the shared-mode address. `busRd` and `busWr` are never high together, and at most one chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration word write enable |
| cfgWrData | input | CFG_W | Configuration write value |
| cfgRdData | output | CFG_W | Configuration word as read |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqInternal | input | 1 | Access targets internal space; external cycle bypassed |
| muxMode | input | 1 | 1 = shared address/data, 0 = split |
| reqCs | input | CS_W | Chip-select area index |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| busCs | output | NUM_CS | Active-high chip selects |
| busAle | output | 1 | Address latch strobe |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busAddr | output | ADDR_W | Address pins (split mode) |
| busDataOut | output | DATA_W | Data bus output value |
| busDataOe | output | 1 | Data bus drive enable |
| busDataIn | input | DATA_W | Data bus input value |
| readData | output | DATA_W | Last sampled read data |
| busDone | output | 1 | One-cycle completion pulse |

## Verification
Every bus output is a decode of registered state, so each state's values show up in the cycle that follows the edge that entered that state. Phase k of a cycle is the k-th cycle after the accepting edge. The bench reference model tracks phase k and compares all outputs at each falling edge. Under that model, `busDone` falls in phase 1 for internal requests and in phase 2 or 3 plus the idle cycle for external ones. `readData` is checked from the falling edge right after the sampling edge. A configuration write appears on `cfgRdData` at the falling edge after the write edge. Cycle lengths are also counted explicitly for every combination of mode, direction, area and enable bit.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TI,
    ST_INT
  } seqState_t;

  typedef struct packed {
    logic load;        // capture request fields
    logic csOn;        // chip select active
    logic ale;         // address latch strobe
    logic rd;          // read strobe
    logic wr;          // write strobe
    logic addrOnData;  // shared mode address phase
    logic addrPins;    // split mode address pins active
    logic dataOut;     // drive write data
    logic sample;      // capture read data at end of this state
  } busStrobe_t;

endpackage

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqInternal,
  input  logic       muxMode,
  input  logic       idleEnSel,
  output busStrobe_t stb,
  output logic       reqReady,
  output logic       busDone
);

  seqState_t state, stateNext;
  logic writeLat, muxLat;
  logic insertIdle;

  assign insertIdle = !writeLat && idleEnSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      writeLat <= 1'b0;
      muxLat   <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && reqValid) begin
        writeLat <= reqWrite;
        muxLat   <= muxMode;
      end
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = reqInternal ? ST_INT : ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = muxLat ? ST_T3 : (insertIdle ? ST_TI : ST_IDLE);
      ST_T3:   stateNext = insertIdle ? ST_TI : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  logic inT1, inT2, inT3, strobeState, lastStrobe;
  assign inT1 = (state == ST_T1);
  assign inT2 = (state == ST_T2);
  assign inT3 = (state == ST_T3);
  assign strobeState = muxLat ? (inT2 || inT3) : inT2;
  assign lastStrobe  = muxLat ? inT3 : inT2;

  always_comb begin
    stb            = '0;
    stb.load       = (state == ST_IDLE) && reqValid;
    stb.csOn       = inT1 || inT2 || inT3;
    stb.ale        = muxLat && inT1;
    stb.rd         = strobeState && !writeLat;
    stb.wr         = strobeState && writeLat;
    stb.addrOnData = muxLat && inT1;
    stb.addrPins   = !muxLat && (inT1 || inT2);
    stb.dataOut    = writeLat && (strobeState || (!muxLat && inT1));
    stb.sample     = lastStrobe && !writeLat;
  end

  assign reqReady = (state == ST_IDLE);
  assign busDone  = (state == ST_TI) || (state == ST_INT) || (lastStrobe && !insertIdle);

endmodule

// File: rtl/extbus_dpath.sv
module extbus_dpath
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 2,
  parameter int CFG_W  = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              idleEnSel,
  output logic [NUM_CS-1:0] busCs,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] readData
);

  logic [NUM_CS-1:0] idleEn;
  logic [CS_W-1:0]   csLat;
  logic [ADDR_W-1:0] addrLat;
  logic [DATA_W-1:0] wdataLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleEn   <= '1;
      csLat    <= '0;
      addrLat  <= '0;
      wdataLat <= '0;
      readData <= '0;
    end else begin
      if (cfgWrEn) begin
        for (int n = 0; n < NUM_CS; n++) idleEn[n] <= cfgWrData[2*n+1];
      end
      if (stb.load) begin
        csLat    <= reqCs;
        addrLat  <= reqAddr;
        wdataLat <= reqWdata;
      end
      if (stb.sample) readData <= busDataIn;
    end
  end

  // configuration view: enables on odd bits below 2*NUM_CS, other odd bits fixed high
  for (genvar b = 0; b < CFG_W; b++) begin : g_cfgBit
    if (b % 2 == 0) begin : g_even
      assign cfgRdData[b] = 1'b0;
    end else if (b / 2 < NUM_CS) begin : g_en
      assign cfgRdData[b] = idleEn[b/2];
    end else begin : g_fix
      assign cfgRdData[b] = 1'b1;
    end
  end

  assign idleEnSel = idleEn[csLat];

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign busCs[n] = stb.csOn && (csLat == CS_W'(n));
  end

  assign busAddr    = stb.addrPins ? addrLat : '0;
  assign busDataOe  = stb.addrOnData || stb.dataOut;
  assign busDataOut = stb.addrOnData ? DATA_W'(addrLat) :
                      (stb.dataOut ? wdataLat : '0);

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 2,
  parameter int CFG_W  = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqInternal,
  input  logic              muxMode,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [NUM_CS-1:0] busCs,
  output logic              busAle,
  output logic              busRd,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] readData,
  output logic              busDone
);

  busStrobe_t stb;
  logic idleEnSel;

  extbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqInternal(reqInternal), .muxMode(muxMode), .idleEnSel(idleEnSel),
    .stb(stb), .reqReady(reqReady), .busDone(busDone)
  );

  extbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CFG_W(CFG_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .idleEnSel(idleEnSel), .busCs(busCs), .busAddr(busAddr), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .readData(readData)
  );

  assign busAle = stb.ale;
  assign busRd  = stb.rd;
  assign busWr  = stb.wr;

endmodule

// File: rtl/extbus_chk.sv
module extbus_chk #(
  parameter int NUM_CS = 2,
  parameter int CFG_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [CFG_W-1:0]  cfgRdData,
  input logic              reqReady,
  input logic [NUM_CS-1:0] busCs,
  input logic              busAle,
  input logic              busRd,
  input logic              busWr,
  input logic              busDataOe,
  input logic              busDone
);

  function automatic logic [CFG_W-1:0] fixedMask();
    logic [CFG_W-1:0] m = '0;
    for (int b = 0; b < CFG_W; b++) if (b % 2 == 0 || b / 2 >= NUM_CS) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [CFG_W-1:0] fixedOnes();
    logic [CFG_W-1:0] m = '0;
    for (int b = 0; b < CFG_W; b++) if (b % 2 == 1 && b / 2 >= NUM_CS) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [CFG_W-1:0] FIX_MASK = fixedMask();
  localparam logic [CFG_W-1:0] FIX_ONES = fixedOnes();

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & FIX_MASK) == FIX_ONES); // R2

  AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    busAle |=> (busRd || busWr)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busDone && busCs == '0) |-> (!busRd && !busWr && !busAle && !busDataOe)); // R5

  AST_WRITE_ENDS_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busWr) |-> $past(busDone)); // R6

  AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (busCs == '0 && !busDone && !busDataOe)); // R10

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busCs) && !(busRd && busWr)); // R11

endmodule

bind extbus_seq extbus_chk #(.NUM_CS(NUM_CS), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/sim_extbus_seq.sv
`timescale 1ns/1ps
module sim_extbus_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqInternal = 1'b0, muxMode = 1'b0;
  logic [0:0] reqCs = '0;
  logic [15:0] reqAddr = '0, reqWdata = '0, busDataIn = '0;
  logic reqReady, busAle, busRd, busWr, busDataOe, busDone;
  logic [1:0] busCs;
  logic [15:0] busAddr, busDataOut, readData;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  extbus_seq u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int phase, len, mCs;
  bit mW, mMux, mInt, rdSeen;
  logic [1:0] mEn;
  logic [15:0] mAddr, mWd, expRd;

  always @(posedge clk) begin
    if (!rstN) begin
      phase <= 0; len <= 0; mEn <= 2'b11; rdSeen <= 0; expRd <= '0;
      mW <= 0; mMux <= 0; mInt <= 0; mCs <= 0; mAddr <= '0; mWd <= '0;
    end else begin
      if (cfgWrEn) mEn <= {cfgWrData[3], cfgWrData[1]};
      if (phase == 0) begin
        if (reqValid) begin
          automatic bit idl = !reqWrite && !reqInternal && mEn[reqCs];
          mW <= reqWrite; mMux <= muxMode; mInt <= reqInternal; mCs <= int'(reqCs);
          mAddr <= reqAddr; mWd <= reqWdata;
          len <= reqInternal ? 1 : ((muxMode ? 3 : 2) + (idl ? 1 : 0));
          phase <= 1;
        end
      end else begin
        if (!mW && !mInt && phase == (mMux ? 3 : 2)) begin
          expRd <= busDataIn; rdSeen <= 1;
        end
        phase <= (phase == len) ? 0 : phase + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit csSt = 0, stbSt = 0, ale = 0, rd = 0, wr = 0, dn = 0, oe = 0;
      automatic logic [15:0] dout = '0, adr = '0;
      automatic logic [1:0] cs = '0;
      automatic string tag;
      if (phase == 0) tag = "R10";
      else if (mInt) tag = "R8";
      else if (phase > (mMux ? 3 : 2)) tag = "R5";
      else if (mMux) tag = "R3";
      else tag = "R4";
      if (phase != 0) begin
        if (mInt) dn = 1;
        else begin
          csSt  = phase <= (mMux ? 3 : 2);
          stbSt = mMux ? (phase == 2 || phase == 3) : (phase == 2);
          ale   = mMux && phase == 1;
          rd    = stbSt && !mW;
          wr    = stbSt && mW;
          dn    = (phase == len);
          if (ale) begin oe = 1; dout = mAddr; end
          else if (mW && (stbSt || (!mMux && phase == 1))) begin oe = 1; dout = mWd; end
          if (!mMux && csSt) adr = mAddr;
          if (csSt) cs = 2'(1 << mCs);
        end
      end
      check({reqReady, busCs, busAle, busRd, busWr, busDone, busDataOe} ==
            {phase == 0, cs, ale, rd, wr, dn, oe}, tag,
            {reqReady, busCs, busAle, busRd, busWr, busDone, busDataOe},
            {phase == 0, cs, ale, rd, wr, dn, oe});
      if (oe) check(busDataOut == dout, "R11 data bus", busDataOut, dout);
      check(busAddr == adr, "R4 address pins", busAddr, adr);
      if (rdSeen) check(readData == expRd, "R9 read data", readData, expRd);
    end
  end

  task automatic cfgWrite(input logic [15:0] v, input logic [15:0] expRead, input string tag);
    @(posedge clk); #1; cfgWrEn = 1; cfgWrData = v;
    @(posedge clk); #1; cfgWrEn = 0;
    @(negedge clk);
    check(cfgRdData == expRead, tag, cfgRdData, expRead);
  endtask

  task automatic doReq(input bit mux, input bit wr, input bit cs, input bit intl,
                       input int expLen, input string tag);
    int cnt;
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    muxMode = mux; reqWrite = wr; reqCs = cs; reqInternal = intl;
    reqAddr = 16'h4000 + 16'(cycles); reqWdata = 16'hC000 ^ 16'(cycles);
    busDataIn = 16'h5A00 + 16'(cycles);
    reqValid = 1;
    @(posedge clk); #1; reqValid = 0;
    cnt = 0;
    do begin
      @(negedge clk); cnt++;
    end while (!busDone && cnt < 10);
    check(cnt == expLen, tag, cnt, expLen);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(cfgRdData == 16'hAAAA, "R1 reset value", cfgRdData, 16'hAAAA);
    check(reqReady == 1'b1 && busCs == 2'b00, "R10 reset idle", {reqReady, busCs}, 3'b100);

    cfgWrite(16'h0000, 16'hAAA0, "R2 clear all");
    cfgWrite(16'hFFFF, 16'hAAAA, "R2 set all");
    cfgWrite(16'h5555, 16'hAAA0, "R2 inverse pattern");
    cfgWrite(16'h0008, 16'hAAA8, "R7 area1 only");
    cfgWrite(16'h0002, 16'hAAA2, "R7 area0 only");

    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 2; c++)
          for (int e = 0; e < 2; e++) begin
            automatic logic [15:0] v = '0;
            automatic int expLen;
            v[2*c+1] = e[0];
            v[2*(1-c)+1] = !e[0];
            cfgWrite(v, 16'hAAA0 | v, "R7 enable write");
            expLen = (m ? 3 : 2) + ((w == 0 && e == 1) ? 1 : 0);
            doReq(m[0], w[0], c[0], 1'b0, expLen,
                  w ? "R6 write length" : (e ? "R5 idle length" : "R3 read length"));
          end

    cfgWrite(16'hAAAA, 16'hAAAA, "R1 restore");
    doReq(1'b1, 1'b0, 1'b0, 1'b1, 1, "R8 internal read");
    doReq(1'b0, 1'b1, 1'b1, 1'b1, 1, "R8 internal write");

    // R10: request raised while busy is ignored
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    muxMode = 1; reqWrite = 0; reqCs = 0; reqInternal = 0; busDataIn = 16'h1234;
    reqValid = 1;
    @(posedge clk); #1; reqWrite = 1; reqCs = 1;
    repeat (2) @(posedge clk);
    #1 reqValid = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(reqReady == 1'b1 && busCs == 2'b00, "R10 busy request ignored", {reqReady, busCs}, 3'b100);
    check(readData == 16'h1234, "R9 read kept", readData, 16'h1234);

    doReq(1'b0, 1'b1, 1'b0, 1'b0, 2, "R6 split write");
    doReq(1'b1, 1'b0, 1'b1, 1'b0, 4, "R5 shared read idle");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      nFails++;
      $display("FAIL R10 watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule